// File: doc/BRIEF.md
# Multi-Exception Priority Resolver

This block picks the one exception to accept when a single instruction has raised several exception flags at once. It handles two situations. The first is an instruction that moves data to or from memory twice. The second is a delayed branch that is resolved together with its delay-slot instruction as one indivisible unit. In the second situation the slot may itself make two data transfers. Each flag group carries four exception types. The types are ranked, highest first: address error, translation miss, protection violation and first-write-to-page. A fixed table assigns each type a level from 1 to 4 in that same order.

For a two-transfer instruction, every flag of the first transfer outranks every flag of the second. For a branch/slot pair, the branch's level 1 and 2 checks come first, then the slot's level 1 and 2 checks. If the slot has two transfers, its first transfer is checked before its second. After that, level 3 is checked across branch and slot together, then level 4 in the same way. A tie at level 3 or level 4 goes to the branch. The block reports whether an exception was taken, an encoded identifier, and whether the winner came from the slot or second transfer. It also drives a signal that suppresses the branch's return-address write when the slot's winning exception is of a re-execution kind. The outputs are registered by default.

Top module: `exc_prio_resolver`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs are cleared to 0 on that edge, whatever the inputs are.
- R2: When no flag that the current mode uses is set, `taken_o` and `pr_inh_o` are 0 on the next cycle.
- R3: Flag bit positions are bit 0 address error, bit 1 translation miss, bit 2 protection violation and bit 3 first-write-to-page. Within one flag group, the lowest set bit wins.
- R4: Outside pair mode (`pair_i`=0) with `dual_i`=1, any set bit of `flg_a_i` (first transfer) beats every bit of `flg_b_i` (second transfer).
- R5: With `pair_i`=0 and `dual_i`=0, `flg_b_i` is ignored. `flg_c_i` is ignored unless both `pair_i` and `dual_i` are 1.
- R6: In pair mode, `flg_a_i` is the branch and `flg_b_i` is the slot. Branch bits 0 and 1 outrank slot bits 0 and 1, and slot bits 0 and 1 outrank any bit 2 or bit 3 of either group.
- R7: In pair mode with `dual_i`=1, `flg_c_i` is the slot's second transfer. Its bits 0 and 1 rank below the slot's first-transfer bits 0 and 1 and above any bit 2 or bit 3.
- R8: In pair mode, any set bit 2 in any group beats any bit 3. Between groups at the same level 3 or 4, the order is branch, then slot first transfer, then slot second transfer.
- R9: `id_o[1:0]` is the winning type and `id_o[3:2]` is the group: 0 for a, 1 for b, 2 for c. `src_o` is 1 exactly when the group is not 0.
- R10: `pr_inh_o` is 1 only when `pair_i` is 1, an exception is taken from group b or c, and `reexec_i` has a 1 at the winning type's bit position.
- R11: The outputs reflect the inputs sampled at the previous rising edge, so each result appears one cycle after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_i | input | 1 | Current instruction is a branch/slot pair |
| dual_i | input | 1 | Two data transfers (the slot's, in pair mode) |
| flg_a_i | input | 4 | Flags: first transfer or branch |
| flg_b_i | input | 4 | Flags: second transfer or slot (first transfer) |
| flg_c_i | input | 4 | Flags: slot second transfer (pair mode only) |
| reexec_i | input | 4 | Per-type mark: slot re-execution kind |
| taken_o | output | 1 | An exception was accepted |
| id_o | output | 4 | Encoded winner {group, type} |
| src_o | output | 1 | 0 for branch or first transfer, 1 for slot or second transfer |
| pr_inh_o | output | 1 | Inhibit the branch's return-address write |

## Verification
Every output is due one rising edge after its inputs are captured. The bench therefore applies inputs at a falling edge and compares the outputs at the following falling edge, once the single register stage has updated. A further check samples just before the rising edge to confirm that a new input has not yet reached the outputs. In reset, the outputs are sampled on the falling edge after an edge where reset was high. A reference priority model in the bench covers every single flag and every ordered flag pair in all four mode combinations. Named cases then target the ties, the ignored groups and the inhibit.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;
   // number of flag groups: a (branch / xfer 1), b (slot / xfer 2), c (slot xfer 2)
   localparam int unsigned NUM_GRP = 3;

   // position in the search order when resolving a branch/slot pair
   function automatic int unsigned pair_rank(int unsigned g, int unsigned t, int unsigned split);
      if (t < split) return g * split + t;
      return NUM_GRP * split + (t - split) * NUM_GRP + g;
   endfunction
endpackage

// File: rtl/exc_first_pick.sv
module exc_first_pick #(
   parameter int unsigned N = 12
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o,
   output logic         any_o
);
   if (N < 2) begin : g_bad_n
      $error("exc_first_pick: N must be at least 2");
   end

   // isolate the lowest set bit: lower index means higher priority
   assign gnt_o = req_i & (~req_i + N'(1));
   assign any_o = |req_i;
endmodule

// File: rtl/exc_rank_map.sv
module exc_rank_map
   import exc_prio_pkg::*;
#(
   parameter int unsigned NUM_TYPES = 4,
   parameter int unsigned SPLIT_LVL = 2,
   localparam int unsigned N = NUM_GRP * NUM_TYPES
) (
   input  logic         pair_i,
   input  logic [N-1:0] flat_i,
   output logic [N-1:0] ord_o,
   input  logic [N-1:0] gnt_i,
   output logic [N-1:0] win_o
);
   logic [N-1:0] fwd_perm;
   logic [N-1:0] back_perm;

   // in single mode the flat order {grp, type} is already the priority order
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      for (genvar t = 0; t < NUM_TYPES; t++) begin : g_typ
         localparam int unsigned K = g * NUM_TYPES + t;
         localparam int unsigned P = pair_rank(g, t, SPLIT_LVL);
         assign fwd_perm[P]  = flat_i[K];
         assign back_perm[K] = gnt_i[P];
      end
   end

   assign ord_o = pair_i ? fwd_perm  : flat_i;
   assign win_o = pair_i ? back_perm : gnt_i;
endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
   import exc_prio_pkg::*;
#(
   parameter int unsigned NUM_TYPES = 4,
   parameter int unsigned SPLIT_LVL = 2,
   parameter bit          REG_OUT   = 1'b1,
   localparam int unsigned TW   = $clog2(NUM_TYPES),
   localparam int unsigned GW   = $clog2(NUM_GRP),
   localparam int unsigned ID_W = GW + TW
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 pair_i,
   input  logic                 dual_i,
   input  logic [NUM_TYPES-1:0] flg_a_i,
   input  logic [NUM_TYPES-1:0] flg_b_i,
   input  logic [NUM_TYPES-1:0] flg_c_i,
   input  logic [NUM_TYPES-1:0] reexec_i,
   output logic                 taken_o,
   output logic [ID_W-1:0]      id_o,
   output logic                 src_o,
   output logic                 pr_inh_o
);
   localparam int unsigned N = NUM_GRP * NUM_TYPES;

   if (NUM_TYPES < 2 || (1 << TW) != NUM_TYPES) begin : g_bad_types
      $error("exc_prio_resolver: NUM_TYPES must be a power of two, at least 2");
   end
   if (SPLIT_LVL > NUM_TYPES) begin : g_bad_split
      $error("exc_prio_resolver: SPLIT_LVL exceeds NUM_TYPES");
   end

   logic [NUM_TYPES-1:0] use_b, use_c;
   logic [N-1:0]         flat, ord, gnt, win;
   logic                 any_d, src_d, inh_d;
   logic [GW-1:0]        grp_d;
   logic [TW-1:0]        typ_d;

   // groups that the current mode does not use are masked off
   assign use_b = (pair_i | dual_i) ? flg_b_i : '0;
   assign use_c = (pair_i & dual_i) ? flg_c_i : '0;
   assign flat  = {use_c, use_b, flg_a_i};

   exc_rank_map #(.NUM_TYPES(NUM_TYPES), .SPLIT_LVL(SPLIT_LVL)) u_map (
      .pair_i (pair_i),
      .flat_i (flat),
      .ord_o  (ord),
      .gnt_i  (gnt),
      .win_o  (win)
   );

   exc_first_pick #(.N(N)) u_pick (
      .req_i (ord),
      .gnt_o (gnt),
      .any_o (any_d)
   );

   always_comb begin
      grp_d = '0;
      typ_d = '0;
      for (int k = 0; k < N; k++) begin
         if (win[k]) begin
            grp_d = GW'(k / NUM_TYPES);
            typ_d = TW'(k % NUM_TYPES);
         end
      end
   end

   assign src_d = any_d && (grp_d != '0);
   assign inh_d = pair_i && src_d && reexec_i[typ_d];

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            taken_o  <= 1'b0;
            id_o     <= '0;
            src_o    <= 1'b0;
            pr_inh_o <= 1'b0;
         end else begin
            taken_o  <= any_d;
            id_o     <= {grp_d, typ_d};
            src_o    <= src_d;
            pr_inh_o <= inh_d;
         end
      end

      assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
         (flg_a_i == '0 && flg_b_i == '0 && flg_c_i == '0) |=> (!taken_o && !pr_inh_o));
      assert_pick_R3: assert property (@(posedge clk) disable iff (rst)
         $onehot0(gnt) && ((|ord) == (|win)));
      assert_first_xfer_R4: assert property (@(posedge clk) disable iff (rst)
         (!pair_i && flg_a_i != '0) |=> (taken_o && id_o[ID_W-1:TW] == '0));
      assert_single_R5: assert property (@(posedge clk) disable iff (rst)
         (!pair_i && !dual_i) |=> !src_o);
      assert_branch_first_R6: assert property (@(posedge clk) disable iff (rst)
         (pair_i && flg_a_i[SPLIT_LVL-1:0] != '0) |=> (taken_o && !src_o));
      assert_inh_src_R10: assert property (@(posedge clk) disable iff (rst)
         pr_inh_o |-> (taken_o && src_o));
   end else begin : g_comb
      assign taken_o  = any_d;
      assign id_o     = {grp_d, typ_d};
      assign src_o    = src_d;
      assign pr_inh_o = inh_d;
   end
endmodule

// File: tb/sim_exc_prio_resolver.sv
module sim_exc_prio_resolver;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pair_i = 1'b0, dual_i = 1'b0;
   logic [3:0] flg_a_i = '0, flg_b_i = '0, flg_c_i = '0, reexec_i = '0;
   logic       taken_o, src_o, pr_inh_o;
   logic [3:0] id_o;
   int         checks = 0, fails = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   exc_prio_resolver u0 (
      .clk(clk), .rst(rst), .pair_i(pair_i), .dual_i(dual_i),
      .flg_a_i(flg_a_i), .flg_b_i(flg_b_i), .flg_c_i(flg_c_i), .reexec_i(reexec_i),
      .taken_o(taken_o), .id_o(id_o), .src_o(src_o), .pr_inh_o(pr_inh_o)
   );

   // reference priority model: {taken, id[3:0], src, inh}
   function automatic logic [6:0] ref_eval(input logic pr, input logic du,
                                           input logic [11:0] f, input logic [3:0] rx);
      int seq[12];
      int n = 0;
      int ng;
      if (!pr) begin
         for (int g = 0; g < (du ? 2 : 1); g++)
            for (int t = 0; t < 4; t++) begin seq[n] = g * 4 + t; n++; end
      end else begin
         ng = du ? 3 : 2;
         for (int g = 0; g < ng; g++)
            for (int t = 0; t < 2; t++) begin seq[n] = g * 4 + t; n++; end
         for (int t = 2; t < 4; t++)
            for (int g = 0; g < ng; g++) begin seq[n] = g * 4 + t; n++; end
      end
      for (int i = 0; i < n; i++) begin
         if (f[seq[i]]) begin
            int g = seq[i] / 4;
            int t = seq[i] % 4;
            return {1'b1, 2'(g), 2'(t), g != 0, pr && g != 0 && rx[t]};
         end
      end
      return 7'd0;
   endfunction

   task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got {tk,id,src,inh}=%b expected %b", tag, got, exp);
      end
   endtask

   function automatic logic [6:0] outs();
      return {taken_o, id_o, src_o, pr_inh_o};
   endfunction

   // drive at a falling edge, compare at the next falling edge (one register stage)
   task automatic apply(input string tag, input logic pr, input logic du,
                        input logic [11:0] f, input logic [3:0] rx);
      @(negedge clk);
      pair_i = pr; dual_i = du;
      {flg_c_i, flg_b_i, flg_a_i} = f;
      reexec_i = rx;
      @(negedge clk);
      chk(tag, outs(), ref_eval(pr, du, f, rx));
   endtask

   task automatic apply_exp(input string tag, input logic pr, input logic du,
                            input logic [11:0] f, input logic [3:0] rx, input logic [6:0] exp);
      @(negedge clk);
      pair_i = pr; dual_i = du;
      {flg_c_i, flg_b_i, flg_a_i} = f;
      reexec_i = rx;
      @(negedge clk);
      chk(tag, outs(), exp);
   endtask

   function automatic string mode_tag(input logic pr, input logic du);
      if (!pr) return du ? "R4" : "R5";
      return du ? "R7" : "R6";
   endfunction

   task automatic t_reset();
      rst = 1'b1;
      pair_i = 1'b1; dual_i = 1'b1;
      flg_a_i = 4'hF; flg_b_i = 4'hF; flg_c_i = 4'hF; reexec_i = 4'hF;
      @(negedge clk); @(negedge clk);
      chk("R1 reset", outs(), 7'd0);
      rst = 1'b0;
   endtask

   task automatic t_idle();
      for (int m = 0; m < 4; m++)
         apply_exp("R2 idle", m[1], m[0], 12'h000, 4'hF, 7'd0);
      // only ignored groups carry flags: still idle
      apply_exp("R2 R5 ignored b", 1'b0, 1'b0, 12'h0F0, 4'hF, 7'd0);
      apply_exp("R2 R5 ignored c", 1'b1, 1'b0, 12'hF00, 4'hF, 7'd0);
   endtask

   task automatic t_latency();
      apply_exp("R11 pre", 1'b0, 1'b0, 12'h000, 4'h0, 7'd0);
      @(negedge clk);
      flg_a_i = 4'b0100;
      #1;
      chk("R11 not yet", outs(), 7'd0);
      @(negedge clk);
      chk("R11 one cycle", outs(), {1'b1, 4'h2, 1'b0, 1'b0});
   endtask

   task automatic t_singles();
      for (int m = 0; m < 4; m++)
         for (int b = 0; b < 12; b++)
            apply(mode_tag(m[1], m[0]), m[1], m[0], 12'(1) << b, 4'(b * 5 + m));
   endtask

   task automatic t_pairs();
      for (int m = 0; m < 4; m++)
         for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
               apply(mode_tag(m[1], m[0]), m[1], m[0], (12'(1) << i) | (12'(1) << j),
                     4'(i * 3 + j));
   endtask

   task automatic t_directed();
      // R3: within one group the lowest bit wins
      apply_exp("R3 type order", 1'b0, 1'b0, 12'h00C, 4'h0, {1'b1, 4'h2, 1'b0, 1'b0});
      // R4: first transfer page-write beats second transfer address error
      apply_exp("R4 xfer order", 1'b0, 1'b1, 12'h018, 4'hF, {1'b1, 4'h3, 1'b0, 1'b0});
      // R6: slot level 1 beats branch level 3
      apply_exp("R6 slot lvl1", 1'b1, 1'b0, 12'h014, 4'h0, {1'b1, 4'h4, 1'b1, 1'b0});
      // R7: slot first transfer lvl2 beats slot second transfer lvl1
      apply_exp("R7 slot xfer", 1'b1, 1'b1, 12'h120, 4'h0, {1'b1, 4'h5, 1'b1, 1'b0});
      // R7: slot second transfer lvl1 beats branch lvl3
      apply_exp("R7 vs lvl3", 1'b1, 1'b1, 12'h104, 4'h0, {1'b1, 4'h8, 1'b1, 1'b0});
      // R8: level 3 tie goes to branch
      apply_exp("R8 tie", 1'b1, 1'b0, 12'h044, 4'hF, {1'b1, 4'h2, 1'b0, 1'b0});
      // R8: slot level 3 beats branch level 4
      apply_exp("R8 lvl3>lvl4", 1'b1, 1'b0, 12'h048, 4'hF, {1'b1, 4'h6, 1'b1, 1'b1});
      // R9: encoding of group c
      apply_exp("R9 encode", 1'b1, 1'b1, 12'h200, 4'h0, {1'b1, 4'h9, 1'b1, 1'b0});
      // R10: inhibit follows reexec bit of winning type
      apply_exp("R10 inh on", 1'b1, 1'b0, 12'h010, 4'b0001, {1'b1, 4'h4, 1'b1, 1'b1});
      apply_exp("R10 inh off", 1'b1, 1'b0, 12'h010, 4'b1110, {1'b1, 4'h4, 1'b1, 1'b0});
      apply_exp("R10 no pair", 1'b0, 1'b1, 12'h010, 4'hF, {1'b1, 4'h4, 1'b1, 1'b0});
      apply_exp("R10 branch win", 1'b1, 1'b0, 12'h011, 4'hF, {1'b1, 4'h0, 1'b0, 1'b0});
   endtask

   initial begin
      t_reset();
      t_idle();
      t_latency();
      t_directed();
      t_singles();
      t_pairs();
      t_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule